// File: doc/BRIEF.md
# Linked-List Hardware Queue Manager

This block holds a set of hardware queues of descriptor indices. The queues do not have FIFOs of their own. Each queue is a singly linked list threaded through one shared link RAM, which holds one next-pointer per descriptor. Each queue keeps a head, a tail and an entry count, so a push or a pop is one operation in one clock. A descriptor can leave one queue and join another without any payload moving, so producers and consumers on different agents can hand descriptors to each other by index alone. A queue may hold descriptors of any kind mixed together.

Requests arrive on a simple request port. Each cycle can carry one push (queue, descriptor index) and one pop (queue). A pop answers one cycle later with the index at the head of the queue, or with an all-ones null value if the queue was empty. A contiguous window of queue numbers, chosen by parameter, drives level-sensitive pending outputs. Transmit DMA channels or interrupt logic use these outputs as triggers, so queues in that window are meant for hardware triggering. All other queues serve any purpose, such as free-descriptor pools.

Top module: `qm_hw_queue_mgr`

## Requirements
- R1: After reset every queue is empty, every pending output is low and `pop_rsp_valid` is low.
- R2: Within one queue, descriptors come out of pops in the order in which they were pushed.
- R3: A pop of an empty queue returns the null index (all ones in `IDX_W` bits) and leaves that queue empty.
- R4: `pop_rsp_valid` is high in exactly the cycle after a cycle with `pop_valid` high, and the response index belongs to that pop.
- R5: `q_pend[i]` is high exactly while queue `PEND_BASE+i` holds at least one descriptor. It changes in the cycle after the push or pop that makes that queue non-empty or empty.
- R6: When a push and a pop name the same queue in one cycle, the pop is served first. On an empty queue the pop returns null and the pushed index stays queued. On a queue holding one entry, the old entry is returned and the new one becomes the head.
- R7: A push whose descriptor index is not below `NUM_DESC` is ignored. No queue and no pending output changes.
- R8: A push and a pop that name different queues in one cycle both take effect. A descriptor popped from one queue may be pushed in that same cycle to another queue and is later returned from there.
- R9: Queues are independent: pushes to and pops from one queue never change the contents or order of any other queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request this cycle |
| push_queue | input | $clog2(NUM_Q) | Queue to append to |
| push_index | input | $clog2(NUM_DESC+1) | Descriptor index to append |
| pop_valid | input | 1 | Pop request this cycle |
| pop_queue | input | $clog2(NUM_Q) | Queue to take the head of |
| pop_rsp_valid | output | 1 | Pop response present (one cycle after the request) |
| pop_rsp_index | output | $clog2(NUM_DESC+1) | Popped index, or all ones when the queue was empty |
| q_pend | output | PEND_CNT | Non-empty flags of queues PEND_BASE to PEND_BASE+PEND_CNT-1 |

## Verification
Every result is due exactly one clock edge after its request. The pop response register and the count registers that drive the pending outputs are both written on the edge that takes the request. The bench drives a request on a falling edge, lets one rising edge pass and compares the response and all pending bits on the next falling edge. Before that edge it computes the expected values from its own list model of every queue. In that model a pop is applied before a push and an out-of-range push is dropped. Sweeps over a small configuration fill and drain every queue and cover same-queue push/pop at depths zero, one and two. A long pseudo-random run of mixed requests follows.

// File: rtl/qm_pkg.sv
package qm_pkg;

   // width of a descriptor index; one code above the last descriptor is reserved for null
   function automatic int unsigned qm_idx_width(input int unsigned num_desc);
      return $clog2(num_desc + 1);
   endfunction

   // width of a queue number
   function automatic int unsigned qm_q_width(input int unsigned num_q);
      return (num_q < 2) ? 1 : $clog2(num_q);
   endfunction

   // outcome of the pop side of one request cycle
   typedef enum logic [1:0] {
      POP_IDLE  = 2'd0,
      POP_EMPTY = 2'd1,
      POP_TAKE  = 2'd2
   } qm_pop_kind_e;

endpackage

// File: rtl/qm_link_ram.sv
module qm_link_ram #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [IDX_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_addr,
   output logic [IDX_W-1:0] rd_data
);

   logic [IDX_W-1:0] link_mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en && (int'(wr_addr) < int'(DEPTH))) begin
         link_mem[wr_addr] <= wr_data;
      end
   end

   always_comb begin
      if (int'(rd_addr) < int'(DEPTH)) begin
         rd_data = link_mem[rd_addr];
      end else begin
         rd_data = '0;
      end
   end

   AST_LINK_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_addr) < int'(DEPTH)) && (int'(wr_data) < int'(DEPTH))); // R8

endmodule

// File: rtl/qm_queue_state.sv
module qm_queue_state #(
   parameter int unsigned NUM_Q    = 64,
   parameter int unsigned NUM_DESC = 256,
   parameter int unsigned QW       = 6,
   parameter int unsigned IDX_W    = 9,
   parameter int unsigned CNT_W    = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_v,
   input  logic [QW-1:0]    push_q,
   input  logic [IDX_W-1:0] push_idx,
   input  logic             pop_v,
   input  logic [QW-1:0]    pop_q,
   input  logic [IDX_W-1:0] link_rd_data,
   output logic [IDX_W-1:0] link_rd_addr,
   output logic             link_wr_en,
   output logic [IDX_W-1:0] link_wr_addr,
   output logic [IDX_W-1:0] link_wr_data,
   output qm_pkg::qm_pop_kind_e pop_kind,
   output logic [IDX_W-1:0] pop_head,
   output logic [NUM_Q-1:0] nonempty
);

   import qm_pkg::*;

   logic [IDX_W-1:0] head_r [NUM_Q];
   logic [IDX_W-1:0] tail_r [NUM_Q];
   logic [CNT_W-1:0] cnt_r  [NUM_Q];

   logic             pop_hit;
   logic             same_q;
   logic [CNT_W-1:0] push_cnt_after_pop;

   // pop side: served first
   always_comb begin
      pop_hit  = pop_v && (cnt_r[pop_q] != '0);
      pop_head = head_r[pop_q];
      if (!pop_v) begin
         pop_kind = POP_IDLE;
      end else if (pop_hit) begin
         pop_kind = POP_TAKE;
      end else begin
         pop_kind = POP_EMPTY;
      end
   end

   assign link_rd_addr = head_r[pop_q];
   assign same_q       = push_v && pop_v && (push_q == pop_q);

   // push side sees the queue as the pop left it
   always_comb begin
      push_cnt_after_pop = cnt_r[push_q] - CNT_W'(same_q && pop_hit);
      link_wr_en   = push_v && (push_cnt_after_pop != '0);
      link_wr_addr = tail_r[push_q];
      link_wr_data = push_idx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int q = 0; q < int'(NUM_Q); q++) begin
            head_r[q] <= '0;
            tail_r[q] <= '0;
            cnt_r[q]  <= '0;
         end
      end else begin
         for (int q = 0; q < int'(NUM_Q); q++) begin
            logic             dec;
            logic             inc;
            logic [CNT_W-1:0] mid;
            dec = pop_hit && (int'(pop_q) == q);
            inc = push_v && (int'(push_q) == q);
            mid = cnt_r[q] - CNT_W'(dec);
            cnt_r[q] <= mid + CNT_W'(inc);
            if (inc && (mid == '0)) begin
               head_r[q] <= push_idx;
            end else if (dec) begin
               head_r[q] <= link_rd_data;
            end
            if (inc) begin
               tail_r[q] <= push_idx;
            end
         end
      end
   end

   for (genvar g = 0; g < int'(NUM_Q); g++) begin : g_flag
      assign nonempty[g] = (cnt_r[g] != '0);
   end

   AST_EMPTY_POP_KEEPS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_v && !pop_hit && !same_q) |=> (cnt_r[$past(pop_q)] == '0)); // R3
   AST_SAME_Q_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_hit && same_q) |=> (cnt_r[$past(pop_q)] == $past(cnt_r[pop_q]))); // R6
   AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (push_v && !pop_v) |=> (cnt_r[$past(push_q)] == $past(cnt_r[push_q]) + 1'b1)); // R9
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cnt_r[pop_q]) <= int'(NUM_DESC))); // R9

endmodule

// File: rtl/qm_pend_map.sv
module qm_pend_map #(
   parameter int unsigned PEND_CNT = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PEND_CNT-1:0] window_nonempty,
   output logic [PEND_CNT-1:0] pend
);

   for (genvar g = 0; g < int'(PEND_CNT); g++) begin : g_pend
      assign pend[g] = window_nonempty[g];
   end

   AST_PEND_NO_GLITCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pend == '0)); // R1

endmodule

// File: rtl/qm_hw_queue_mgr.sv
module qm_hw_queue_mgr #(
   parameter int unsigned NUM_Q     = 64,
   parameter int unsigned NUM_DESC  = 256,
   parameter int unsigned PEND_BASE = 32,
   parameter int unsigned PEND_CNT  = 16,
   localparam int unsigned QW       = qm_pkg::qm_q_width(NUM_Q),
   localparam int unsigned IDX_W    = qm_pkg::qm_idx_width(NUM_DESC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push_valid,
   input  logic [QW-1:0]       push_queue,
   input  logic [IDX_W-1:0]    push_index,
   input  logic                pop_valid,
   input  logic [QW-1:0]       pop_queue,
   output logic                pop_rsp_valid,
   output logic [IDX_W-1:0]    pop_rsp_index,
   output logic [PEND_CNT-1:0] q_pend
);

   import qm_pkg::*;

   localparam int unsigned CNT_W = IDX_W;
   localparam logic [IDX_W-1:0] NULL_IDX = '1;

   if (NUM_Q < 2 || (1 << QW) != NUM_Q) begin : g_bad_nq
      $error("NUM_Q must be a power of two of at least 2");
   end
   if (NUM_DESC < 2) begin : g_bad_nd
      $error("NUM_DESC must be at least 2");
   end
   if (PEND_CNT < 1 || PEND_BASE + PEND_CNT > NUM_Q) begin : g_bad_pend
      $error("pending window must lie inside the queue range");
   end

   logic             push_ok;
   logic [IDX_W-1:0] link_rd_addr;
   logic [IDX_W-1:0] link_rd_data;
   logic             link_wr_en;
   logic [IDX_W-1:0] link_wr_addr;
   logic [IDX_W-1:0] link_wr_data;
   qm_pop_kind_e     pop_kind;
   logic [IDX_W-1:0] pop_head;
   logic [NUM_Q-1:0] q_nonempty;

   assign push_ok = push_valid && (int'(push_index) < int'(NUM_DESC));

   qm_queue_state #(
      .NUM_Q(NUM_Q), .NUM_DESC(NUM_DESC), .QW(QW), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_state (
      .clk(clk), .rst_n(rst_n),
      .push_v(push_ok), .push_q(push_queue), .push_idx(push_index),
      .pop_v(pop_valid), .pop_q(pop_queue),
      .link_rd_data(link_rd_data), .link_rd_addr(link_rd_addr),
      .link_wr_en(link_wr_en), .link_wr_addr(link_wr_addr), .link_wr_data(link_wr_data),
      .pop_kind(pop_kind), .pop_head(pop_head), .nonempty(q_nonempty)
   );

   qm_link_ram #(
      .DEPTH(NUM_DESC), .IDX_W(IDX_W)
   ) u_link (
      .clk(clk), .rst_n(rst_n),
      .wr_en(link_wr_en), .wr_addr(link_wr_addr), .wr_data(link_wr_data),
      .rd_addr(link_rd_addr), .rd_data(link_rd_data)
   );

   qm_pend_map #(
      .PEND_CNT(PEND_CNT)
   ) u_pend (
      .clk(clk), .rst_n(rst_n),
      .window_nonempty(q_nonempty[PEND_BASE +: PEND_CNT]),
      .pend(q_pend)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pop_rsp_valid <= 1'b0;
         pop_rsp_index <= NULL_IDX;
      end else begin
         pop_rsp_valid <= (pop_kind != POP_IDLE);
         pop_rsp_index <= (pop_kind == POP_TAKE) ? pop_head : NULL_IDX;
      end
   end

   // pending-window bookkeeping for checks only
   logic             push_in_window;
   logic [QW-1:0]    push_pend_bit;
   assign push_in_window = (int'(push_queue) >= int'(PEND_BASE)) &&
                           (int'(push_queue) <  int'(PEND_BASE + PEND_CNT));
   assign push_pend_bit  = push_queue - QW'(PEND_BASE);

   AST_RSP_FOLLOWS_POP: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |=> pop_rsp_valid); // R4
   AST_NO_RSP_WITHOUT_POP: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_valid |=> !pop_rsp_valid); // R4
   AST_EMPTY_GIVES_NULL: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_kind == POP_EMPTY) |=> (pop_rsp_index == NULL_IDX)); // R3
   AST_TAKE_IS_REAL: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_kind == POP_TAKE) |=> (int'(pop_rsp_index) < int'(NUM_DESC))); // R2
   AST_PEND_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && push_in_window) |=> q_pend[$past(push_pend_bit)]); // R5
   AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && !push_ok && !pop_valid) |=> $stable(q_nonempty)); // R7

endmodule

// File: tb/qm_hw_queue_mgr_test.sv
`timescale 1ns/1ps
module qm_hw_queue_mgr_test;

   localparam int NQ    = 8;
   localparam int ND    = 16;
   localparam int PB    = 4;
   localparam int PC    = 3;
   localparam int QW    = 3;
   localparam int IW    = 5;
   localparam int NULLV = 31;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_valid = 1'b0;
   logic [QW-1:0] push_queue = '0;
   logic [IW-1:0] push_index = '0;
   logic          pop_valid = 1'b0;
   logic [QW-1:0] pop_queue = '0;
   logic          pop_rsp_valid;
   logic [IW-1:0] pop_rsp_index;
   logic [PC-1:0] q_pend;

   int  nchk = 0;
   int  nerr = 0;
   bit  done = 0;
   int  model [NQ][$];
   bit  in_use [ND];
   int unsigned seed = 32'h1ACE_2B07;

   always #2 clk = ~clk;

   qm_hw_queue_mgr #(.NUM_Q(NQ), .NUM_DESC(ND), .PEND_BASE(PB), .PEND_CNT(PC)) uut (
      .clk(clk), .rst_n(rst_n),
      .push_valid(push_valid), .push_queue(push_queue), .push_index(push_index),
      .pop_valid(pop_valid), .pop_queue(pop_queue),
      .pop_rsp_valid(pop_rsp_valid), .pop_rsp_index(pop_rsp_index), .q_pend(q_pend)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   function automatic int rnd(input int range);
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return int'(seed % range);
   endfunction

   task automatic check_pend(input string req);
      for (int i = 0; i < PC; i++) begin
         chk(q_pend[i] == (model[PB+i].size() != 0), req, int'(q_pend[i]),
             int'(model[PB+i].size() != 0));
      end
   endtask

   // called on a falling edge; returns on the next falling edge after checking
   task automatic op(input bit pv, input int pq, input int pi, input bit ov, input int oq,
                     input string req);
      int expv;
      expv = NULLV;
      push_valid = pv;  push_queue = QW'(pq);  push_index = IW'(pi);
      pop_valid  = ov;  pop_queue  = QW'(oq);
      if (ov && model[oq].size() > 0) begin
         expv = model[oq].pop_front();
         in_use[expv] = 0;
      end
      if (pv && pi < ND) begin
         model[pq].push_back(pi);
         in_use[pi] = 1;
      end
      @(negedge clk);
      push_valid = 0;  pop_valid = 0;
      if (ov) begin
         chk(pop_rsp_valid == 1'b1, {req, " R4 rsp_valid"}, int'(pop_rsp_valid), 1);
         chk(int'(pop_rsp_index) == expv, {req, " pop index"}, int'(pop_rsp_index), expv);
      end else begin
         chk(pop_rsp_valid == 1'b0, "R4 no rsp", int'(pop_rsp_valid), 0);
      end
      check_pend({req, " R5 pend"});
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(q_pend == '0, "R1 pend after reset", int'(q_pend), 0);
      chk(pop_rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(pop_rsp_valid), 0);
      // R3: every queue empty on pop
      for (int q = 0; q < NQ; q++) op(0, 0, 0, 1, q, "R1 R3 empty pop");

      // R2: order within one queue, then null once drained
      for (int i = 0; i < 5; i++) op(1, 2, i, 0, 0, "R2 fill");
      for (int i = 0; i < 6; i++) op(0, 0, 0, 1, 2, "R2 drain");

      // R5: pend window queues rise and fall
      op(1, PB, 9, 0, 0, "R5 push pend");
      op(1, PB+2, 11, 0, 0, "R5 push pend");
      op(0, 0, 0, 1, PB, "R5 pop pend");
      op(0, 0, 0, 1, PB+2, "R5 pop pend");

      // R6: same-queue push and pop at depth 0, 1 and 2
      op(1, 3, 7, 1, 3, "R6 depth0");
      op(0, 0, 0, 1, 3, "R6 depth0 follow");
      op(1, 3, 8, 0, 0, "R6 setup");
      op(1, 3, 9, 1, 3, "R6 depth1");
      op(0, 0, 0, 1, 3, "R6 depth1 follow");
      op(0, 0, 0, 1, 3, "R6 depth1 empty");
      op(1, PB+1, 1, 0, 0, "R6 setup");
      op(1, PB+1, 2, 0, 0, "R6 setup");
      op(1, PB+1, 3, 1, PB+1, "R6 depth2");
      op(0, 0, 0, 1, PB+1, "R6 depth2 follow");
      op(0, 0, 0, 1, PB+1, "R6 depth2 follow");
      op(0, 0, 0, 1, PB+1, "R6 depth2 empty");

      // R7: out-of-range index ignored
      op(1, 5, ND, 0, 0, "R7 bad index");
      op(1, PB, ND+3, 0, 0, "R7 bad index pend");
      op(0, 0, 0, 1, 5, "R7 queue still empty");
      op(0, 0, 0, 1, PB, "R7 pend queue still empty");

      // R8: move a descriptor between queues in one cycle
      op(1, 0, 10, 0, 0, "R8 setup");
      op(1, 6, 10, 1, 0, "R8 move");
      op(0, 0, 0, 1, 6, "R8 moved out");
      op(0, 0, 0, 1, 0, "R8 source empty");

      // R9: sweep, two descriptors per queue, drained in reverse queue order
      for (int q = 0; q < NQ; q++) begin
         op(1, q, 2*q, 0, 0, "R9 fill");
         op(1, q, 2*q+1, 0, 0, "R9 fill");
      end
      for (int q = NQ-1; q >= 0; q--) begin
         for (int k = 0; k < 3; k++) op(0, 0, 0, 1, q, "R9 drain");
      end

      // mixed pseudo-random traffic over the free pool
      for (int n = 0; n < 1500; n++) begin
         bit pv;
         bit ov;
         int pq;
         int oq;
         int pi;
         pv = (rnd(3) != 0);
         ov = (rnd(2) != 0);
         pq = rnd(NQ);
         oq = (rnd(4) == 0) ? pq : rnd(NQ);
         pi = ND;
         if (pv) begin
            int start;
            start = rnd(ND);
            for (int k = 0; k < ND; k++) begin
               if (pi == ND && !in_use[(start + k) % ND]) pi = (start + k) % ND;
            end
            if (rnd(16) == 0) pi = ND + rnd(NULLV - ND);
         end
         op(pv, pq, pi, ov, oq, "R2 R6 R8 R9 random");
      end

      done = 1;
      summary();
      $finish;
   end

endmodule